// File: doc/BRIEF.md
# Inset Picture Window Overlay Generator

This block draws a small inset picture over the main television raster. It runs on the pixel clock. It recovers column and line position from the main horizontal and vertical sync pulses, and the active level of each sync pulse is selectable. From a pair of 6-bit coarse position registers it places a rectangular window, which is a ring border around an active area. Inside the active area it passes already-unpacked YUV samples. In the border ring it shows a coded border colour.

The block drives a switch enable that tells the downstream video switch when to take the inset signal. A blank control, a solid test fill and a transparent border code change what appears inside the window. When the inset is not shown, the block holds fixed levels: zero luma and mid-scale chroma, so that later clamp circuits always see correct reference levels. If the programmed window would start inside a keep-out zone near main sync, the window is suppressed for the whole frame.

Top module: `inset_window_gen`

## Requirements
- R1: While reset is low, and until the first sync edges arrive, the outputs are Y=0, U=32, V=32 with the switch enable low.
- R2: The active sync level is the input XOR its polarity bit (0: active high, 1: active low). In the clock after an edge first samples the active horizontal level, the column counter is 0. It then counts once per clock and saturates at its maximum. The line counter becomes 0 on an active vertical start. Otherwise it increments on each horizontal start and saturates. A vertical start takes priority over a horizontal start in the same cycle.
- R3: The window origin is column pos_x*4 and line pos_y*4. A border ring 2 columns wide and 2 lines tall surrounds the active area. The active area is 114x70 when size_large=1 and 84x52 when it is 0. Outputs are registered, so they show the column and line held in the previous clock.
- R4: In the active area, fill_sel 00 passes pix_y/pix_u/pix_v. Code 01 gives red (19,23,59), code 10 gives green (37,14,10) and code 11 gives blue (7,59,27), all as (Y,U,V). The switch enable is high.
- R5: In the border ring, border_code selects the colour: 000 black (0,32,32), 001 70% white (44,32,32), 100 blue, 101 green, 110 red, 111 white (63,32,32). Codes 010 and 011 are transparent, with the switch low and idle levels.
- R6: pip_blank=1 makes the whole window, ring included, black (0,32,32) with the switch high. This overrides fill and every border code, including the transparent codes.
- R7: Outside the window, and whenever the switch enable is low, the outputs are Y=0, U=32, V=32.
- R8: If pos_x*4 < keep_px or pos_y*4 < keep_ln, the switch enable stays low everywhere.
- R9: With pip_on=0 the switch enable stays low everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Main horizontal sync, synchronous to clk |
| vsync_in | input | 1 | Main vertical sync, synchronous to clk |
| hsync_pol | input | 1 | 0: horizontal sync active high, 1: active low |
| vsync_pol | input | 1 | 0: vertical sync active high, 1: active low |
| pos_x | input | 6 | Horizontal coarse position |
| pos_y | input | 6 | Vertical coarse position |
| size_large | input | 1 | 1: large window, 0: small window |
| pip_on | input | 1 | Window enable |
| pip_blank | input | 1 | Force whole window black |
| fill_sel | input | 2 | Solid test fill select |
| border_code | input | 3 | Border colour code |
| keep_px | input | 10 | Horizontal keep-out limit, in columns |
| keep_ln | input | 9 | Vertical keep-out limit, in lines |
| pix_y | input | 6 | Inset luma sample |
| pix_u | input | 6 | Inset U sample, offset binary |
| pix_v | input | 6 | Inset V sample, offset binary |
| out_y | output | 6 | Luma to DAC |
| out_u | output | 6 | U to DAC |
| out_v | output | 6 | V to DAC |
| pip_sw | output | 1 | Inset switch enable |

## Verification
Most faults inside the block come from a wrong column or line counter. Such a fault moves a window edge by one or more pixels or lines, and it appears at pip_sw and the colour outputs one clock after the first misplaced position. An edge detector that keys on the wrong polarity shifts the whole window by the width of the sync pulse in the first line where it matters. A wrong priority among blank, fill and border shows up as a wrong colour on the first pixel of the ring or of the active area. The bench compares every output in every clock with a model built from the requirements, so any of these faults is reported within the first frame that reaches the window.

// File: rtl/inset_window_pkg.sv
// Package of shared types and colour constants for the inset window generator.
// Chroma is offset binary: code 32 is zero colour difference.
package inset_window_pkg;

    typedef struct packed {
        logic [5:0] y;
        logic [5:0] u;
        logic [5:0] v;
    } yuv_t;

    typedef enum logic [1:0] {
        RGN_OUT    = 2'd0,
        RGN_RING   = 2'd1,
        RGN_ACTIVE = 2'd2
    } region_t;

    localparam yuv_t COL_BLACK = '{y: 6'd0,  u: 6'd32, v: 6'd32};
    localparam yuv_t COL_GREY  = '{y: 6'd44, u: 6'd32, v: 6'd32};
    localparam yuv_t COL_WHITE = '{y: 6'd63, u: 6'd32, v: 6'd32};
    localparam yuv_t COL_RED   = '{y: 6'd19, u: 6'd23, v: 6'd59};
    localparam yuv_t COL_GREEN = '{y: 6'd37, u: 6'd14, v: 6'd10};
    localparam yuv_t COL_BLUE  = '{y: 6'd7,  u: 6'd59, v: 6'd27};

    // Colour of an opaque border code; transparent codes are handled by the caller.
    function automatic yuv_t border_colour(input logic [2:0] code);
        case (code)
            3'b000:  return COL_BLACK;
            3'b001:  return COL_GREY;
            3'b100:  return COL_BLUE;
            3'b101:  return COL_GREEN;
            3'b110:  return COL_RED;
            default: return COL_WHITE;
        endcase
    endfunction

    // Solid fill colour for a non-zero fill code.
    function automatic yuv_t fill_colour(input logic [1:0] code);
        case (code)
            2'b01:   return COL_RED;
            2'b10:   return COL_GREEN;
            default: return COL_BLUE;
        endcase
    endfunction

endpackage

// File: rtl/sync_edge.sv
// Detects the start of an active sync pulse.
// Assumes the sync input is already synchronous to clk. The active level is
// input XOR pol; start is high in the first cycle the active level is seen.
module sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_raw,
    input  logic pol,
    output logic start
);
    logic act;
    logic act_d;

    // Normalise polarity and compare with the previous cycle.
    always_comb begin
        act   = sync_raw ^ pol;
        start = act & ~act_d;
    end

    // Remember the last active level.
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= 1'b0;
        else        act_d <= act;
    end
endmodule

// File: rtl/raster_counter.sv
// Column and line counters of the main raster.
// Assumes the starts come from sync_edge. Both counters saturate, so a
// missing sync parks the position beyond any window.
module raster_counter #(
    parameter int HCW = 10,
    parameter int VCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_start,
    input  logic           v_start,
    output logic [HCW-1:0] hcnt,
    output logic [VCW-1:0] vcnt
);
    localparam logic [HCW-1:0] HMAX = '1;
    localparam logic [VCW-1:0] VMAX = '1;

    // Column: clear on a horizontal start, else count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)              hcnt <= HMAX;
        else if (h_start)        hcnt <= '0;
        else if (hcnt != HMAX)   hcnt <= hcnt + 1'b1;
    end

    // Line: clear on a vertical start, else step on each horizontal start.
    always_ff @(posedge clk) begin
        if (!rst_n)                      vcnt <= VMAX;
        else if (v_start)                vcnt <= '0;
        else if (h_start && vcnt != VMAX) vcnt <= vcnt + 1'b1;
    end
endmodule

// File: rtl/window_locator.sv
// Classifies the current raster position as outside, border ring or active
// area, and decides whether the window may be shown at all (on bit and sync
// keep-out zone). Purely combinational.
module window_locator
    import inset_window_pkg::*;
#(
    parameter int HCW      = 10,
    parameter int VCW      = 9,
    parameter int XSTEP    = 4,
    parameter int YSTEP    = 4,
    parameter int ACT_W_L  = 114,
    parameter int ACT_H_L  = 70,
    parameter int ACT_W_S  = 84,
    parameter int ACT_H_S  = 52,
    parameter int RING_PX  = 2,
    parameter int RING_LN  = 2
) (
    input  logic [HCW-1:0] hcnt,
    input  logic [VCW-1:0] vcnt,
    input  logic [5:0]     pos_x,
    input  logic [5:0]     pos_y,
    input  logic           size_large,
    input  logic           pip_on,
    input  logic [HCW-1:0] keep_px,
    input  logic [VCW-1:0] keep_ln,
    output region_t        region,
    output logic           win_en
);
    logic [HCW-1:0] x0, ax0, ax1, x1, wid;
    logic [VCW-1:0] y0, ay0, ay1, y1, hgt;
    logic in_oh, in_ah, in_ov, in_av;

    // Window edges from the coarse position and the size select.
    always_comb begin
        wid = size_large ? HCW'(ACT_W_L) : HCW'(ACT_W_S);
        hgt = size_large ? VCW'(ACT_H_L) : VCW'(ACT_H_S);
        x0  = HCW'(pos_x) * HCW'(XSTEP);
        y0  = VCW'(pos_y) * VCW'(YSTEP);
        ax0 = x0 + HCW'(RING_PX);
        ay0 = y0 + VCW'(RING_LN);
        ax1 = ax0 + wid;
        ay1 = ay0 + hgt;
        x1  = ax1 + HCW'(RING_PX);
        y1  = ay1 + VCW'(RING_LN);
    end

    // Region decode and suppression by the on bit and the keep-out zone.
    always_comb begin
        in_oh  = (hcnt >= x0)  && (hcnt < x1);
        in_ah  = (hcnt >= ax0) && (hcnt < ax1);
        in_ov  = (vcnt >= y0)  && (vcnt < y1);
        in_av  = (vcnt >= ay0) && (vcnt < ay1);
        win_en = pip_on && (x0 >= keep_px) && (y0 >= keep_ln);
        if (!(in_oh && in_ov))   region = RGN_OUT;
        else if (in_ah && in_av) region = RGN_ACTIVE;
        else                     region = RGN_RING;
    end
endmodule

// File: rtl/pixel_mux.sv
// Picks the output colour and switch enable by priority:
// suppression/outside, then blank, then border or fill/samples. Registered.
module pixel_mux
    import inset_window_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  region_t    region,
    input  logic       win_en,
    input  logic       pip_blank,
    input  logic [1:0] fill_sel,
    input  logic [2:0] border_code,
    input  yuv_t       pix,
    output yuv_t       out_px,
    output logic       pip_sw
);
    yuv_t nxt_px;
    logic nxt_sw;
    logic ring_clear;

    // Next colour and switch state for this position.
    always_comb begin
        ring_clear = (border_code[2:1] == 2'b01);
        nxt_px     = COL_BLACK;
        nxt_sw     = 1'b0;
        if (win_en && region != RGN_OUT) begin
            if (pip_blank) begin
                nxt_sw = 1'b1;
            end else if (region == RGN_RING) begin
                if (!ring_clear) begin
                    nxt_px = border_colour(border_code);
                    nxt_sw = 1'b1;
                end
            end else begin
                nxt_px = (fill_sel == 2'b00) ? pix : fill_colour(fill_sel);
                nxt_sw = 1'b1;
            end
        end
    end

    // Output register feeding the DACs and the switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_px <= COL_BLACK;
            pip_sw <= 1'b0;
        end else begin
            out_px <= nxt_px;
            pip_sw <= nxt_sw;
        end
    end
endmodule

// File: rtl/inset_window_gen.sv
// Top of the inset window overlay generator. Recovers raster position from
// main sync, locates the window and muxes inset samples, border and fill
// colours onto the outputs. All inputs are synchronous to the pixel clock.
module inset_window_gen
    import inset_window_pkg::*;
#(
    parameter int HCW     = 10,
    parameter int VCW     = 9,
    parameter int XSTEP   = 4,
    parameter int YSTEP   = 4,
    parameter int ACT_W_L = 114,
    parameter int ACT_H_L = 70,
    parameter int ACT_W_S = 84,
    parameter int ACT_H_S = 52,
    parameter int RING_PX = 2,
    parameter int RING_LN = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync_in,
    input  logic           vsync_in,
    input  logic           hsync_pol,
    input  logic           vsync_pol,
    input  logic [5:0]     pos_x,
    input  logic [5:0]     pos_y,
    input  logic           size_large,
    input  logic           pip_on,
    input  logic           pip_blank,
    input  logic [1:0]     fill_sel,
    input  logic [2:0]     border_code,
    input  logic [HCW-1:0] keep_px,
    input  logic [VCW-1:0] keep_ln,
    input  logic [5:0]     pix_y,
    input  logic [5:0]     pix_u,
    input  logic [5:0]     pix_v,
    output logic [5:0]     out_y,
    output logic [5:0]     out_u,
    output logic [5:0]     out_v,
    output logic           pip_sw
);
    logic           h_start, v_start;
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    region_t        region;
    logic           win_en;
    yuv_t           pix, out_px;

    // Sample bundle and output unpacking.
    always_comb begin
        pix   = '{y: pix_y, u: pix_u, v: pix_v};
        out_y = out_px.y;
        out_u = out_px.u;
        out_v = out_px.v;
    end

    sync_edge u_hedge (.clk(clk), .rst_n(rst_n), .sync_raw(hsync_in),
                       .pol(hsync_pol), .start(h_start));
    sync_edge u_vedge (.clk(clk), .rst_n(rst_n), .sync_raw(vsync_in),
                       .pol(vsync_pol), .start(v_start));

    raster_counter #(.HCW(HCW), .VCW(VCW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .h_start(h_start), .v_start(v_start),
        .hcnt(hcnt), .vcnt(vcnt));

    window_locator #(
        .HCW(HCW), .VCW(VCW), .XSTEP(XSTEP), .YSTEP(YSTEP),
        .ACT_W_L(ACT_W_L), .ACT_H_L(ACT_H_L), .ACT_W_S(ACT_W_S), .ACT_H_S(ACT_H_S),
        .RING_PX(RING_PX), .RING_LN(RING_LN)
    ) u_loc (
        .hcnt(hcnt), .vcnt(vcnt), .pos_x(pos_x), .pos_y(pos_y),
        .size_large(size_large), .pip_on(pip_on), .keep_px(keep_px),
        .keep_ln(keep_ln), .region(region), .win_en(win_en));

    pixel_mux u_mux (
        .clk(clk), .rst_n(rst_n), .region(region), .win_en(win_en),
        .pip_blank(pip_blank), .fill_sel(fill_sel), .border_code(border_code),
        .pix(pix), .out_px(out_px), .pip_sw(pip_sw));
endmodule

// File: rtl/inset_window_chk.sv
// Property checker for inset_window_gen, attached by bind.
module inset_window_chk #(
    parameter int HCW   = 10,
    parameter int XSTEP = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pip_on,
    input logic           pip_blank,
    input logic [5:0]     pos_x,
    input logic [HCW-1:0] keep_px,
    input logic [5:0]     out_y,
    input logic [5:0]     out_u,
    input logic [5:0]     out_v,
    input logic           pip_sw,
    input logic           h_start,
    input logic [HCW-1:0] hcnt
);
    logic [HCW-1:0] org_x;
    assign org_x = HCW'(pos_x) * HCW'(XSTEP);

    // R9
    on_bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pip_on |=> !pip_sw);

    // R7
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pip_sw |-> (out_y == 6'd0 && out_u == 6'd32 && out_v == 6'd32));

    // R6
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pip_blank |=> (out_y == 6'd0 && out_u == 6'd32 && out_v == 6'd32));

    // R8
    keepout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (org_x < keep_px) |=> !pip_sw);

    // R2
    col_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_start |=> (hcnt == '0));

    // R2
    col_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == '1 && !h_start) |=> (hcnt == '1));
endmodule

bind inset_window_gen inset_window_chk #(.HCW(HCW), .XSTEP(XSTEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .pip_on(pip_on), .pip_blank(pip_blank),
    .pos_x(pos_x), .keep_px(keep_px), .out_y(out_y), .out_u(out_u),
    .out_v(out_v), .pip_sw(pip_sw), .h_start(h_start), .hcnt(hcnt));

// File: tb/tb_inset_window_gen.sv
`timescale 1ns/1ps
module tb_inset_window_gen;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, hsync_pol = 1'b0, vsync_pol = 1'b0;
    logic [5:0] pos_x = '0, pos_y = '0;
    logic       size_large = 1'b0, pip_on = 1'b0, pip_blank = 1'b0;
    logic [1:0] fill_sel = '0;
    logic [2:0] border_code = '0;
    logic [9:0] keep_px = '0;
    logic [8:0] keep_ln = '0;
    logic [5:0] pix_y = '0, pix_u = '0, pix_v = '0;
    logic [5:0] out_y, out_u, out_v;
    logic       pip_sw;

    inset_window_gen dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .pos_x(pos_x), .pos_y(pos_y),
        .size_large(size_large), .pip_on(pip_on), .pip_blank(pip_blank),
        .fill_sel(fill_sel), .border_code(border_code), .keep_px(keep_px),
        .keep_ln(keep_ln), .pix_y(pix_y), .pix_u(pix_u), .pix_v(pix_v),
        .out_y(out_y), .out_u(out_u), .out_v(out_v), .pip_sw(pip_sw));

    int    n_chk = 0, n_fail = 0;
    bit    chk_en = 1'b0, done = 1'b0;
    int    m_hc = 1023, m_vc = 511;
    bit    m_hd = 1'b0, m_vd = 1'b0;
    logic [18:0] exp_o = {6'd0, 6'd32, 6'd32, 1'b0};
    string exp_tag = "R1";

    // Expected {Y,U,V,sw} at column hc, line vc, from the requirements.
    function automatic logic [18:0] model(input int hc, input int vc, output string tag);
        int x0, y0, w, h;
        bit in_o, in_a;
        logic [17:0] c;
        x0 = pos_x * 4;  y0 = pos_y * 4;
        w = size_large ? 114 : 84;  h = size_large ? 70 : 52;
        in_o = hc >= x0 && hc < x0 + w + 4 && vc >= y0 && vc < y0 + h + 4;
        in_a = hc >= x0 + 2 && hc < x0 + 2 + w && vc >= y0 + 2 && vc < y0 + 2 + h;
        if (!in_o) begin tag = "R7 (R2,R3 position)"; return {18'h00820, 1'b0}; end
        if (!pip_on) begin tag = "R9"; return {18'h00820, 1'b0}; end
        if (x0 < keep_px || y0 < keep_ln) begin tag = "R8"; return {18'h00820, 1'b0}; end
        if (pip_blank) begin tag = "R6"; return {6'd0, 6'd32, 6'd32, 1'b1}; end
        if (in_a) begin
            tag = "R4 (R3 active area)";
            case (fill_sel)
                2'b00: c = {pix_y, pix_u, pix_v};
                2'b01: c = {6'd19, 6'd23, 6'd59};
                2'b10: c = {6'd37, 6'd14, 6'd10};
                default: c = {6'd7, 6'd59, 6'd27};
            endcase
            return {c, 1'b1};
        end
        tag = "R5 (R3 ring)";
        case (border_code)
            3'b000: c = {6'd0, 6'd32, 6'd32};
            3'b001: c = {6'd44, 6'd32, 6'd32};
            3'b010, 3'b011: return {18'h00820, 1'b0};
            3'b100: c = {6'd7, 6'd59, 6'd27};
            3'b101: c = {6'd37, 6'd14, 6'd10};
            3'b110: c = {6'd19, 6'd23, 6'd59};
            default: c = {6'd63, 6'd32, 6'd32};
        endcase
        return {c, 1'b1};
    endfunction

    // Reference raster position and expected next output (R2 counter rules).
    always @(posedge clk) begin
        bit ha, va, hs, vs;
        string t;
        if (!rst_n) begin
            m_hc = 1023; m_vc = 511; m_hd = 0; m_vd = 0;
            exp_o = {6'd0, 6'd32, 6'd32, 1'b0}; exp_tag = "R1";
        end else begin
            exp_o = model(m_hc, m_vc, t);
            exp_tag = t;
            ha = hsync_in ^ hsync_pol;  va = vsync_in ^ vsync_pol;
            hs = ha && !m_hd;           vs = va && !m_vd;
            if (hs) m_hc = 0; else if (m_hc < 1023) m_hc++;
            if (vs) m_vc = 0; else if (hs && m_vc < 511) m_vc++;
            m_hd = ha; m_vd = va;
        end
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_chk++;
            if ({out_y, out_u, out_v, pip_sw} !== exp_o) begin
                n_fail++;
                $display("FAIL %s: got Y=%0d U=%0d V=%0d sw=%0d, expected Y=%0d U=%0d V=%0d sw=%0d",
                         exp_tag, out_y, out_u, out_v, pip_sw,
                         exp_o[18:13], exp_o[12:7], exp_o[6:1], exp_o[0]);
            end
        end
    end

    // One frame of syncs: 4-cycle line pulses, vertical pulse over 2 lines.
    task automatic run_frame(input int nlines, input int llen);
        for (int l = 0; l < nlines; l++)
            for (int c = 0; c < llen; c++) begin
                @(negedge clk);
                hsync_in = (c < 4) ^ hsync_pol;
                vsync_in = (l < 2) ^ vsync_pol;
                pix_y = 6'($urandom); pix_u = 6'($urandom); pix_v = 6'($urandom);
            end
        @(negedge clk);
        hsync_in = hsync_pol;  vsync_in = vsync_pol;
    endtask

    task automatic set_pol(input bit hp, input bit vp);
        @(negedge clk);
        hsync_pol = hp; vsync_pol = vp;
        hsync_in = hp;  vsync_in = vp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got no end of stimulus, expected end within limit");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset levels while reset is held
        n_chk++;
        if ({out_y, out_u, out_v, pip_sw} !== {6'd0, 6'd32, 6'd32, 1'b0}) begin
            n_fail++;
            $display("FAIL R1: got Y=%0d U=%0d V=%0d sw=%0d, expected 0 32 32 0",
                     out_y, out_u, out_v, pip_sw);
        end
        rst_n = 1'b1;
        chk_en = 1'b1;
        pip_on = 1'b1;
        repeat (20) @(negedge clk);   // R1: no window before syncs

        // R9: on bit low over a visible window
        pip_on = 0; pos_x = 3; pos_y = 1; size_large = 0;
        run_frame(62, 110);
        pip_on = 1;

        // R8: horizontal keep-out, then vertical keep-out
        pos_x = 2; pos_y = 0; keep_px = 10'd20;
        run_frame(58, 110);
        keep_px = 0; pos_x = 0; pos_y = 1; keep_ln = 9'd10;
        run_frame(62, 100);
        keep_ln = 0;

        // R6: blank over a transparent ring and a fill
        pos_y = 0; pip_blank = 1; border_code = 3'b010; fill_sel = 2'b10;
        run_frame(58, 100);
        pip_blank = 0;

        // R5, R4, R2: every border code, fill codes and polarity mixes
        for (int b = 0; b < 8; b++) begin
            set_pol(b[0], b[1]);
            border_code = 3'(b); fill_sel = 2'(b); pos_x = 0; pos_y = 0;
            size_large = 0;
            run_frame(58, 100);
        end

        // R3, R4, R5: random large and small windows
        for (int k = 0; k < 4; k++) begin
            set_pol(1'($urandom), 1'($urandom));
            pos_x = 6'($urandom % 16); pos_y = 6'($urandom % 4);
            size_large = 1'($urandom); fill_sel = 2'($urandom);
            border_code = 3'($urandom); pip_blank = (($urandom % 5) == 0);
            run_frame(pos_y * 4 + (size_large ? 74 : 56) + 3, 190);
        end
        pip_blank = 0;
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule